// File: doc/BRIEF.md
# Reset Strap Capture and Reset-Out Sequencer

This block watches a group of configuration strap pins while the primary reset is held low and freezes their values at the clock edge that ends the reset. The frozen values drive a set of decoded configuration outputs:

- bus host direction;
- boot source;
- bus configuration role;
- bus arbiter role;
- transmit clock source;
- PLL multiplier code, with a validity flag;
- two memory window sizes, given as low-address masks.

Three of the frozen straps also appear at fixed bit positions of a read-only control word.

The block also sequences the active-low reset output for the rest of the system. A frozen strap selects between two release modes. In hardware mode the output is released once a synchronized PLL lock indication arrives. In software mode it is released when software writes a reset register with bit 17 set. Once released, the output stays released until the primary reset is asserted again.

Top module: `strap_rst_ctrl`

## Requirements
- R1: While `rst_n` is low the straps are sampled on every rising clock edge. The value sampled at the last rising edge with `rst_n` low is held. Strap pin changes made while `rst_n` is high have no effect on any output.
- R2: `ctl_rdata` carries the frozen straps at these positions: the host-direction strap at bit 31, `strap_gpio[0]` at bit 29 and `strap_gpio[1]` at bit 28. All other bits read 0.
- R3: `bus_rst_oe` equals the frozen host-direction strap: 1 when driving the bus reset pin, 0 when the pin is an input.
- R4: The single-bit role outputs are each a frozen strap pin:
  - `prom_boot` is `strap_gpio[0]`.
  - `bus_cfg_host` is `strap_gpio[1]`.
  - `bus_arb_en` is `strap_gpio[2]`.
  - `txclk_internal` is `strap_ad[6]`, where 1 selects the internal clock and 0 the reference pin.
- R5: `pll_mult` is the frozen `strap_ad[5:0]`. `pll_mult_bad` is 1 exactly when that code is below 16 or above 48.
- R6: `sram_mask` has its low 25+c bits set and the rest clear, where c is the frozen `strap_gpio[6:5]`. This gives 32, 64, 128 and 256 MB for c = 0..3.
- R7: `dram_mask` has its low 27+c bits set and the rest clear, where c is the frozen `strap_gpio[4:3]`. This gives 128, 256, 512 and 1024 MB for c = 0..3.
- R8: When the frozen `strap_ad[7]` is 1 (hardware mode), `rst_out_n` stays low until `pll_lock` has passed a two-flop synchronizer. It rises at the third rising edge after `pll_lock` goes high. Reset register writes have no effect in this mode.
- R9: When the frozen `strap_ad[7]` is 0 (software mode), `rst_out_n` rises at the rising edge where `rst_reg_we` is 1 and `rst_reg_wdata[17]` is 1. Writes with bit 17 clear and the `pll_lock` input have no effect in this mode.
- R10: `rst_out_n` is 0 while `rst_n` is low. Once high, it stays high until `rst_n` is next asserted, whatever `pll_lock` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Primary reset, active low |
| strap_host_dir | input | 1 | Bus reset direction strap |
| strap_ad | input | 8 | Shared address pin straps |
| strap_gpio | input | 7 | General-purpose pin straps |
| pll_lock | input | 1 | Asynchronous PLL lock indication |
| rst_reg_we | input | 1 | Reset register write strobe |
| rst_reg_wdata | input | 32 | Reset register write data |
| rst_out_n | output | 1 | System reset output, active low |
| bus_rst_oe | output | 1 | Bus reset pin output enable |
| prom_boot | output | 1 | Boot from PROM |
| bus_cfg_host | output | 1 | Chip configures the peripheral bus |
| bus_arb_en | output | 1 | Chip is bus arbiter |
| txclk_internal | output | 1 | Transmit clock from internal source |
| pll_mult | output | 6 | Frozen PLL multiplier code |
| pll_mult_bad | output | 1 | Multiplier code out of range |
| sram_mask | output | 32 | SRAM window address mask |
| dram_mask | output | 32 | DRAM window address mask |
| ctl_rdata | output | 32 | Control word with strap mirror bits |

## Verification
The decoded strap outputs are combinational from the capture flops, so they are valid at the first falling edge after `rst_n` rises. The bench checks them there, after it has already scrambled the strap pins half a cycle earlier. A lock edge driven at a falling edge must show up on `rst_out_n` only at the falling edge after the third rising edge. The bench samples `rst_out_n` at each of the three falling edges before that to catch early release. A software write is presented for one rising edge, and `rst_out_n` is due high at the falling edge that follows it.

// File: rtl/strap_rst_ctrl.sv
module strap_rst_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int SRAM_LG0 = 25,
  parameter int DRAM_LG0 = 27,
  parameter int MULT_LO  = 16,
  parameter int MULT_HI  = 48,
  parameter int REL_BIT  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_host_dir,
  input  logic [7:0]        strap_ad,
  input  logic [6:0]        strap_gpio,
  input  logic              pll_lock,
  input  logic              rst_reg_we,
  input  logic [31:0]       rst_reg_wdata,
  output logic              rst_out_n,
  output logic              bus_rst_oe,
  output logic              prom_boot,
  output logic              bus_cfg_host,
  output logic              bus_arb_en,
  output logic              txclk_internal,
  output logic [5:0]        pll_mult,
  output logic              pll_mult_bad,
  output logic [ADDR_W-1:0] sram_mask,
  output logic [ADDR_W-1:0] dram_mask,
  output logic [31:0]       ctl_rdata
);

  logic [7:0] cap_ad;
  logic [6:0] cap_gpio;
  logic       cap_dir;
  logic       lock_s1, lock_s2;
  logic       released;
  logic       hw_mode;
  logic       unused_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_ad   <= strap_ad;
      cap_gpio <= strap_gpio;
      cap_dir  <= strap_host_dir;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_s1 <= 1'b0;
      lock_s2 <= 1'b0;
    end else begin
      lock_s1 <= pll_lock;
      lock_s2 <= lock_s1;
    end
  end

  assign hw_mode = cap_ad[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      released <= 1'b0;
    else if (!released) begin
      if (hw_mode)
        released <= lock_s2;
      else
        released <= rst_reg_we & rst_reg_wdata[REL_BIT];
    end
  end

  assign unused_wdata = ^{rst_reg_wdata[31:REL_BIT+1], rst_reg_wdata[REL_BIT-1:0]};

  assign rst_out_n      = released;
  assign bus_rst_oe     = cap_dir;
  assign prom_boot      = cap_gpio[0];
  assign bus_cfg_host   = cap_gpio[1];
  assign bus_arb_en     = cap_gpio[2];
  assign txclk_internal = cap_ad[6];
  assign pll_mult       = cap_ad[5:0];
  assign pll_mult_bad   = (int'(cap_ad[5:0]) < MULT_LO) || (int'(cap_ad[5:0]) > MULT_HI);

  assign sram_mask = ~({ADDR_W{1'b1}} << (SRAM_LG0 + int'(cap_gpio[6:5])));
  assign dram_mask = ~({ADDR_W{1'b1}} << (DRAM_LG0 + int'(cap_gpio[4:3])));

  assign ctl_rdata = {cap_dir, 1'b0, cap_gpio[0], cap_gpio[1], 28'd0};

endmodule

// File: rtl/strap_rst_ctrl_chk.sv
module strap_rst_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_out_n,
  input logic        hw_mode,
  input logic        pll_lock,
  input logic        rst_reg_we,
  input logic        rel_bit,
  input logic        bus_rst_oe,
  input logic [31:0] ctl_rdata
);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |=> rst_out_n);

  a_r8_lock_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && $rose(rst_out_n)) |-> $past(pll_lock, 2));

  a_r9_write_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_mode && $rose(rst_out_n)) |-> $past(rst_reg_we && rel_bit));

  a_r1_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ctl_rdata));

  a_r3_dir_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_oe == ctl_rdata[31]);

endmodule

bind strap_rst_ctrl strap_rst_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_out_n  (rst_out_n),
  .hw_mode    (cap_ad[7]),
  .pll_lock   (pll_lock),
  .rst_reg_we (rst_reg_we),
  .rel_bit    (rst_reg_wdata[17]),
  .bus_rst_oe (bus_rst_oe),
  .ctl_rdata  (ctl_rdata)
);

// File: tb/sim_strap_rst_ctrl.sv
module sim_strap_rst_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_host_dir = 1'b0;
  logic [7:0]  strap_ad = '0;
  logic [6:0]  strap_gpio = '0;
  logic        pll_lock = 1'b0;
  logic        rst_reg_we = 1'b0;
  logic [31:0] rst_reg_wdata = '0;
  logic        rst_out_n, bus_rst_oe, prom_boot, bus_cfg_host, bus_arb_en, txclk_internal;
  logic [5:0]  pll_mult;
  logic        pll_mult_bad;
  logic [31:0] sram_mask, dram_mask, ctl_rdata;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_rst_ctrl u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dir, input logic [7:0] ad, input logic [6:0] gp);
    @(negedge clk);
    rst_n = 1'b0;
    strap_host_dir = dir; strap_ad = ad; strap_gpio = gp;
    repeat (3) @(negedge clk);
    chk("R10 low in reset", rst_out_n, 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    strap_host_dir = ~dir; strap_ad = ~ad; strap_gpio = ~gp;
    @(negedge clk);
  endtask

  task automatic sw_write(input logic b17);
    rst_reg_we = 1'b1;
    rst_reg_wdata = 32'hFFFD_FFFF | (32'(b17) << 17);
    @(negedge clk);
    rst_reg_we = 1'b0;
    rst_reg_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      logic [7:0] ad;
      logic [6:0] gp;
      logic dir;
      ad  = {i[0], i[1], 6'(i)};
      gp  = {i[2], i[1], i[4], i[3], i[5], i[0] ^ i[2], i[1] ^ i[3]};
      dir = i[4] ^ i[0];
      do_reset(dir, ad, gp);
      chk("R2 ctl word", ctl_rdata, {dir, 1'b0, gp[0], gp[1], 28'd0});
      chk("R3 oe", bus_rst_oe, dir);
      chk("R4 prom", prom_boot, gp[0]);
      chk("R4 cfg host", bus_cfg_host, gp[1]);
      chk("R4 arb", bus_arb_en, gp[2]);
      chk("R4 txclk", txclk_internal, ad[6]);
      chk("R5 mult", pll_mult, i);
      chk("R5 bad", pll_mult_bad, (i < 16 || i > 48));
      chk("R6 sram", sram_mask, (64'd1 << (25 + gp[6:5])) - 1);
      chk("R7 dram", dram_mask, (64'd1 << (27 + gp[4:3])) - 1);
      chk("R1 held no release", rst_out_n, 0);
    end

    // R8 hardware mode
    do_reset(1'b0, 8'h90, 7'h00);
    sw_write(1'b1);
    chk("R8 sw ignored", rst_out_n, 0);
    pll_lock = 1'b1;
    @(negedge clk); chk("R8 edge1", rst_out_n, 0);
    @(negedge clk); chk("R8 edge2", rst_out_n, 0);
    @(negedge clk); chk("R8 edge3", rst_out_n, 1);
    pll_lock = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 sticky hw", rst_out_n, 1);
    pll_lock = 1'b1;

    // R9 software mode
    do_reset(1'b1, 8'h20, 7'h7F);
    repeat (5) @(negedge clk);
    chk("R9 lock ignored", rst_out_n, 0);
    sw_write(1'b0);
    chk("R9 bit17 clear", rst_out_n, 0);
    sw_write(1'b1);
    chk("R9 release", rst_out_n, 1);
    pll_lock = 1'b0;
    sw_write(1'b0);
    repeat (3) @(negedge clk);
    chk("R10 sticky sw", rst_out_n, 1);
    do_reset(1'b1, 8'h20, 7'h7F);
    chk("R10 re-held", rst_out_n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule